// File: doc/BRIEF.md
# Supply Reset Supervisor with Ramp Watchdog

This block produces the system reset for a logic domain. It watches two digitized supply levels, one meaning the supply is above its upper threshold and one meaning it is below its lower threshold. It also watches a kick signal that the supervised logic toggles while it is healthy. The reset is driven in two complementary forms, one active-high and one active-low. When the supply first becomes good, reset is held for a fixed power-up interval. After that, a watchdog runs.

The watchdog timebase is one up/down counter that models a timing capacitor. After reset is released, the counter descends slowly. A falling edge on the kick input turns it around so that it climbs quickly, and reaching the top level turns it back down. If the counter descends to the bottom level, a reset pulse is issued. During that pulse the counter climbs back to the top, and then reset is released again.

Losing the supply forces reset on the next clock and clears the counter. Recovery repeats the full power-up hold.

All times are counted in prescaler ticks of `TICK_DIV` clocks and scale with `CAP_UNITS`:

| Interval | Length |
|---|---|
| Power-up hold | 1000 ticks per unit |
| Descent from top to bottom | 100 ticks per unit |
| Watchdog reset pulse | 20 ticks per unit |

Top module: `supply_watchdog_supervisor`

## Requirements
- R1: While `supply_lo` is 1, `rst_out` is 1. The reset asserts on the first clock edge that samples `supply_lo` high.
- R2: Supply is accepted as good only after `supply_hi` has been 1 for `GLITCH_CLKS` consecutive clocks with `supply_lo` at 0. A cycle with both levels at 0 restarts this count before acceptance. Once the supply is accepted, that in-between state keeps it accepted.
- R3: After the supply is accepted, `rst_out` stays 1 for 1000*`CAP_UNITS` ticks and is then released. A tick is `TICK_DIV` clocks.
- R4: Kick edges during the power-up hold do not change its length.
- R5: A falling edge of `kick` at least once every 20 ticks keeps `rst_out` at 0 indefinitely.
- R6: With no kicks, `rst_out` rises 100*`CAP_UNITS` ticks after it was released.
- R7: A watchdog reset pulse lasts 20*`CAP_UNITS` ticks. After it, the descent restarts from the top, so the next pulse follows another 100*`CAP_UNITS` ticks later.
- R8: When the supply drops during operation, reset is asserted at once. On recovery the full power-up hold of R3 repeats.
- R9: `rst_out_n` is always the inverse of `rst_out`.
- R10: While `rst_n` is 0 at a clock edge, the block returns to the off state and `rst_out` is 1.
- R11: Kick edges during a watchdog reset pulse do not shorten or lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| supply_hi | input | 1 | Supply is above the upper threshold |
| supply_lo | input | 1 | Supply is below the lower threshold |
| kick | input | 1 | Watchdog kick from the supervised logic, asynchronous; falling edges count |
| rst_out | output | 1 | Active-high reset output |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
The assertions assume that `supply_hi` and `supply_lo` are never 1 together, since they come from the two sides of a hysteresis band. They also assume that `kick` may change at any time, because it is only consumed through the synchronizer. The bench keeps the two supply levels mutually exclusive and changes every input on the falling clock edge. It toggles `kick` with a fixed half-period well inside the 20-tick window. Durations are measured on the outputs within a small window that allows for prescaler phase and the synchronizer delay.

// File: rtl/sup_pkg.sv
// Shared constants and state type for the supply reset supervisor.
// Assumes all time ratios are expressed per capacitance unit, in ticks.
package sup_pkg;
    localparam int HOLD_PER_CAP = 1000;   // power-up hold, ticks
    localparam int FALL_PER_CAP = 100;    // descent top->bottom, ticks
    localparam int RISE_PER_CAP = 20;     // climb bottom->top, ticks
    localparam int TOP_PER_CAP  = 28;     // top level, counter steps
    localparam int BOT_PER_CAP  = 8;      // bottom level (0.4/1.4 of top)
    localparam int DOWN_DIV     = FALL_PER_CAP / RISE_PER_CAP;

    typedef enum logic [2:0] {
        SUP_OFF   = 3'd0,
        SUP_HOLD  = 3'd1,
        SUP_DOWN  = 3'd2,
        SUP_UP    = 3'd3,
        SUP_WDRST = 3'd4
    } sup_state_t;
endpackage

// File: rtl/sup_tick_gen.sv
// Prescaler: emits a one-clock tick every DIV clocks.
// Assumes DIV >= 1; DIV == 1 yields a tick on every clock.
module sup_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            logic [W-1:0] cnt;

            // Free-running divider counter.
            always_ff @(posedge clk) begin
                if (!rst_n) cnt <= '0;
                else if (cnt == W'(DIV - 1)) cnt <= '0;
                else cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == W'(DIV - 1));

            a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sup_kick_edge.sv
// Brings the asynchronous kick into the clock domain with two flops and
// flags its falling edge for one clock. Idle level after reset is high.
module sup_kick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_raw,
    output logic kick_fall
);
    logic meta_q, sync_q, prev_q;

    // Two-flop synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= kick_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign kick_fall = prev_q & ~sync_q;

    a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        kick_fall |=> !kick_fall);
endmodule

// File: rtl/sup_supply_filter.sv
// Qualifies the supply: good only after supply_hi has been seen for
// GLITCH_CLKS consecutive clocks; dropped at once by supply_lo.
// Assumes supply_hi and supply_lo are never both high.
module sup_supply_filter #(
    parameter int GLITCH_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic supply_ok
);
    localparam int W = $clog2(GLITCH_CLKS + 1);
    logic [W-1:0] run_cnt;

    // Persistence counter and accepted flag.
    always_ff @(posedge clk) begin
        if (!rst_n || below_lo) begin
            supply_ok <= 1'b0;
            run_cnt   <= '0;
        end else if (supply_ok) begin
            run_cnt   <= '0;
        end else if (above_hi) begin
            if (run_cnt == W'(GLITCH_CLKS - 1)) begin
                supply_ok <= 1'b1;
                run_cnt   <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    a_r2_ok_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |-> $past(above_hi));
    a_r1_lo_drops_ok: assert property (@(posedge clk) disable iff (!rst_n)
        below_lo |=> !supply_ok);
    a_r2_levels_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(above_hi && below_lo));
endmodule

// File: rtl/supply_watchdog_supervisor.sv
// Supply reset supervisor with a ramp-counter watchdog.
// A single up/down counter models the timing capacitor: it charges during
// power-up hold and watchdog reset, and discharges slowly while running.
// Assumes kick is asynchronous and supply levels are already digitized.
module supply_watchdog_supervisor #(
    parameter int CAP_UNITS   = 1,
    parameter int TICK_DIV    = 2,
    parameter int GLITCH_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_hi,
    input  logic supply_lo,
    input  logic kick,
    output logic rst_out,
    output logic rst_out_n
);
    import sup_pkg::*;

    localparam int TOP_LVL    = TOP_PER_CAP * CAP_UNITS;
    localparam int BOT_LVL    = BOT_PER_CAP * CAP_UNITS;
    localparam int HOLD_TICKS = HOLD_PER_CAP * CAP_UNITS;
    localparam int CNT_W      = $clog2(TOP_LVL + 1);
    localparam int HOLD_W     = $clog2(HOLD_TICKS + 1);
    localparam int SUB_W      = $clog2(DOWN_DIV + 1);
    localparam logic [CNT_W-1:0]  TOP_C  = CNT_W'(TOP_LVL);
    localparam logic [CNT_W-1:0]  BOT_C  = CNT_W'(BOT_LVL);
    localparam logic [HOLD_W-1:0] HOLD_C = HOLD_W'(HOLD_TICKS - 1);
    localparam logic [SUB_W-1:0]  SUB_C  = SUB_W'(DOWN_DIV - 1);

    logic tick, kick_fall, supply_ok;
    sup_state_t state, nxt_state;
    logic [CNT_W-1:0]  ramp_cnt, nxt_cnt;
    logic [HOLD_W-1:0] hold_cnt, nxt_hold;
    logic [SUB_W-1:0]  sub_cnt, nxt_sub;

    sup_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sup_kick_edge u_kick (
        .clk(clk), .rst_n(rst_n), .kick_raw(kick), .kick_fall(kick_fall)
    );

    sup_supply_filter #(.GLITCH_CLKS(GLITCH_CLKS)) u_filt (
        .clk(clk), .rst_n(rst_n), .above_hi(supply_hi), .below_lo(supply_lo),
        .supply_ok(supply_ok)
    );

    // Next-state and ramp-counter decision.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = ramp_cnt;
        nxt_hold  = hold_cnt;
        nxt_sub   = sub_cnt;
        if (supply_lo || !supply_ok) begin
            nxt_state = SUP_OFF;
            nxt_cnt   = '0;
            nxt_hold  = '0;
            nxt_sub   = '0;
        end else begin
            case (state)
                SUP_OFF: nxt_state = SUP_HOLD;
                SUP_HOLD: if (tick) begin
                    if (ramp_cnt < TOP_C) nxt_cnt = ramp_cnt + 1'b1;
                    if (hold_cnt == HOLD_C) begin
                        nxt_state = SUP_DOWN;
                        nxt_cnt   = TOP_C;
                        nxt_hold  = '0;
                        nxt_sub   = '0;
                    end else begin
                        nxt_hold = hold_cnt + 1'b1;
                    end
                end
                SUP_DOWN: if (kick_fall) begin
                    nxt_state = SUP_UP;
                    nxt_sub   = '0;
                end else if (tick) begin
                    if (sub_cnt == SUB_C) begin
                        nxt_sub = '0;
                        nxt_cnt = ramp_cnt - 1'b1;
                        if (ramp_cnt <= BOT_C + 1'b1) nxt_state = SUP_WDRST;
                    end else begin
                        nxt_sub = sub_cnt + 1'b1;
                    end
                end
                SUP_UP, SUP_WDRST: if (tick) begin
                    if (ramp_cnt >= TOP_C - 1'b1) begin
                        nxt_cnt   = TOP_C;
                        nxt_state = SUP_DOWN;
                        nxt_sub   = '0;
                    end else begin
                        nxt_cnt = ramp_cnt + 1'b1;
                    end
                end
                default: nxt_state = SUP_OFF;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SUP_OFF;
            ramp_cnt <= '0;
            hold_cnt <= '0;
            sub_cnt  <= '0;
        end else begin
            state    <= nxt_state;
            ramp_cnt <= nxt_cnt;
            hold_cnt <= nxt_hold;
            sub_cnt  <= nxt_sub;
        end
    end

    assign rst_out   = (state != SUP_DOWN) && (state != SUP_UP);
    assign rst_out_n = ~rst_out;

    logic in_wd, running;
    assign in_wd   = (state == SUP_WDRST);
    assign running = (state == SUP_DOWN) || (state == SUP_UP);

    a_r1_lo_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lo |=> rst_out);
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_cnt <= TOP_C);
    a_r7_wd_starts_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_wd) |-> (ramp_cnt == BOT_C));
    a_r3_release_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (ramp_cnt == TOP_C));
    a_r5_run_above_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (ramp_cnt > BOT_C));
    a_r8_off_discharged: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SUP_OFF) |-> (ramp_cnt == '0));
endmodule

// File: tb/supply_watchdog_supervisor_bench.sv
module supply_watchdog_supervisor_bench;
    localparam int CAP   = 1;
    localparam int TDIV  = 2;
    localparam int GL    = 4;
    localparam int HOLD_CLK = 1000 * CAP * TDIV;
    localparam int FALL_CLK = 100 * CAP * TDIV;
    localparam int RISE_CLK = 20 * CAP * TDIV;
    localparam int KHALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_hi = 1'b0;
    logic supply_lo = 1'b1;
    logic kick = 1'b1;
    logic kick_en = 1'b0;
    logic rst_out, rst_out_n;
    int checks = 0;
    int errors = 0;
    int compl_bad = 0;
    int kph = 0;

    always #10 clk = ~clk;

    supply_watchdog_supervisor #(.CAP_UNITS(CAP), .TICK_DIV(TDIV), .GLITCH_CLKS(GL))
        u_supply_watchdog_supervisor (
        .clk(clk), .rst_n(rst_n), .supply_hi(supply_hi), .supply_lo(supply_lo),
        .kick(kick), .rst_out(rst_out), .rst_out_n(rst_out_n)
    );

    // kick generator: falling edge every 2*KHALF clocks while enabled
    always @(negedge clk) begin
        if (!kick_en) begin
            kick <= 1'b1;
            kph  <= 0;
        end else if (kph == KHALF - 1) begin
            kick <= ~kick;
            kph  <= 0;
        end else begin
            kph <= kph + 1;
        end
    end

    // R9 monitor: outputs must be complementary on every cycle
    always @(negedge clk) if (rst_out === rst_out_n) compl_bad++;

    // stimulus vectors: {hi, lo, kick_en, expected rst_out, clocks[15:0]}
    localparam bit [19:0] VEC [8] = '{
        {1'b0, 1'b1, 1'b0, 1'b1, 16'd20},
        {1'b1, 1'b0, 1'b0, 1'b1, 16'd2},
        {1'b1, 1'b0, 1'b1, 1'b1, 16'd1500},
        {1'b1, 1'b0, 1'b1, 1'b0, 16'd600},
        {1'b1, 1'b0, 1'b1, 1'b0, 16'd1200},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'd200},
        {1'b0, 1'b0, 1'b0, 1'b0, 16'd120},
        {1'b0, 1'b1, 1'b0, 1'b1, 16'd20}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R3";
            4: return "R5";
            5: return "R2 band";
            6: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count clocks until rst_out equals level (bounded)
    task automatic wait_level(input logic level, input int limit, output int n);
        n = 0;
        while (rst_out !== level && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic window(input int act, input int lo_b, input int hi_b,
                          input int exp, input string req);
        chk(act >= lo_b && act <= hi_b, req, act, exp);
    endtask

    int n, hold_quiet, hold_kicked, lows;

    initial begin
        // R10: reset state
        step(3);
        chk(rst_out === 1'b1 && rst_out_n === 1'b0, "R10 reset state", rst_out, 1);
        rst_n = 1'b1;
        step(1);

        // table walk
        for (int i = 0; i < 8; i++) begin
            supply_hi = VEC[i][19];
            supply_lo = VEC[i][18];
            kick_en   = VEC[i][17];
            step(int'(VEC[i][15:0]));
            chk(rst_out === VEC[i][16], vec_tag(i), rst_out, VEC[i][16]);
        end

        // R3: power-up hold length without kicks
        supply_lo = 1'b0; supply_hi = 1'b1;
        wait_level(1'b0, 5000, n);
        hold_quiet = n;
        window(n, HOLD_CLK, HOLD_CLK + GL + TDIV + 4, HOLD_CLK, "R3 hold length");

        // R6: descent with no kicks
        wait_level(1'b1, 1000, n);
        window(n, FALL_CLK - 5*TDIV - 4, FALL_CLK + 5*TDIV + 4, FALL_CLK, "R6 descent time");

        // R7: pulse length and restart of descent
        wait_level(1'b0, 1000, n);
        window(n, RISE_CLK - TDIV - 2, RISE_CLK + TDIV + 2, RISE_CLK, "R7 pulse length");
        wait_level(1'b1, 1000, n);
        window(n, FALL_CLK - 5*TDIV - 4, FALL_CLK + 5*TDIV + 4, FALL_CLK, "R7 descent restarts");

        // R11: kicks during a watchdog pulse do not change it
        kick_en = 1'b1;
        wait_level(1'b0, 1000, n);
        window(n, RISE_CLK - TDIV - 2, RISE_CLK + TDIV + 2, RISE_CLK, "R11 pulse with kicks");

        // R5: kicked system stays out of reset
        lows = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (rst_out !== 1'b0) lows++;
        end
        chk(lows == 0, "R5 kicked no reset", lows, 0);

        // R8: supply drop asserts reset on the next edge
        supply_hi = 1'b0; supply_lo = 1'b1;
        step(1);
        chk(rst_out === 1'b1, "R8 immediate reset", rst_out, 1);
        step(10);

        // R4 + R8: recovery with kicks running repeats full hold, same length
        supply_lo = 1'b0; supply_hi = 1'b1;
        wait_level(1'b0, 5000, n);
        hold_kicked = n;
        window(n, HOLD_CLK, HOLD_CLK + GL + TDIV + 4, HOLD_CLK, "R8 hold after recovery");
        chk(hold_kicked - hold_quiet <= TDIV && hold_quiet - hold_kicked <= TDIV,
            "R4 hold unchanged by kicks", hold_kicked, hold_quiet);

        // R2: glitchy supply (3 clocks high, 1 clock in band) never starts hold
        kick_en = 1'b0;
        supply_hi = 1'b0; supply_lo = 1'b1;
        step(5);
        supply_lo = 1'b0;
        lows = 0;
        for (int i = 0; i < 800; i++) begin
            supply_hi = (i % 4) != 3;
            @(negedge clk);
            if (rst_out !== 1'b1) lows++;
        end
        chk(lows == 0, "R2 glitch filtered", lows, 0);
        supply_hi = 1'b1;
        wait_level(1'b0, 5000, n);
        window(n, HOLD_CLK, HOLD_CLK + GL + TDIV + 4, HOLD_CLK, "R2 hold after steady supply");

        // R9: complementary outputs throughout
        chk(compl_bad == 0, "R9 complement", compl_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule